// File: doc/BRIEF.md
# DDR Column Command Spacing Scheduler

This block sits on the controller side of a double-data-rate graphics memory interface. It takes read and write column requests from an in-order queue, each tagged with the external rank it targets. It then decides the earliest clock cycle in which each request may go out on the command bus. The spacing it enforces keeps the bidirectional data strobe free of conflicts. Strobes from two different ranks must not overlap. A read postamble must not collide with a write preamble. Write recovery must finish before a read follows a write.

Requests arrive through a valid/ready handshake. Ready stays low until the head request may legally issue. The command appears on a one-hot issue strobe, together with its rank, in the same cycle as the handshake. A single configuration input selects CAS latency 2 or 3. Bursts are four beats long, which is two clocks of data. Half-clock gaps are rounded up to whole clocks. Row activation, refresh, bank state and the data path belong to other blocks.

Top module: `ddr_cmd_spacer`

## Requirements
- R1: After reset, with no command yet issued, `reqReady` is 1 and `cmdIssue` is 0. The first request presented after reset issues in the cycle it is presented.
- R2: A command issues in exactly the cycle where `reqValid` and `reqReady` are both 1. `cmdIssue` bit 0 marks a read and bit 1 marks a write, and at most one bit is set. `cmdRank` equals `reqRank` in that cycle.
- R3: A read that follows a read to the same rank may issue 2 cycles after it, with no gap on the bus.
- R4: A read that follows a read to a different rank must wait at least 3 cycles, which is one idle strobe clock.
- R5: A write that follows a write, to any rank, may issue 2 cycles after it.
- R6: A read that follows a write must wait at least 4 cycles: two clocks of burst plus the rounded-up recovery time.
- R7: A write that follows a read must wait at least CAS latency + 3 cycles. That is 5 cycles when `casLat3` = 0 and 6 cycles when `casLat3` = 1.
- R8: `reqReady` stays 0 until the earliest legal cycle for the head request. While it is 0, no command issues.
- R9: The spacing is measured from the last issued command, whatever idle time lies between. A request presented after the required gap has already passed issues in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| casLat3 | input | 1 | 1 selects CAS latency 3, 0 selects CAS latency 2 |
| reqValid | input | 1 | Head request is present |
| reqReady | output | 1 | Head request may issue this cycle |
| reqIsWrite | input | 1 | 1 for write, 0 for read |
| reqRank | input | RANK_W | External rank of the head request |
| cmdIssue | output | 2 | One-hot issue strobe: bit 0 read, bit 1 write |
| cmdRank | output | RANK_W | Rank of the issued command |

## Verification
A wrong record of the last command or of its rank shows up at the next issue. That command leaves too early or too late against the spacing table, or it is held back with no reason. A miscounted elapsed-cycle counter shifts `reqReady` by at least one cycle on the very next back-to-back pair. The bench presents requests back-to-back and after idle stretches. It compares every issue cycle exactly against the earliest legal cycle, so any shift of one cycle is reported at the command where it happens.

// File: rtl/ddr_spacer_pkg.sv
package ddr_spacer_pkg;
  // strobes from control to datapath: which command issues this cycle
  typedef struct packed {
    logic issueRd;
    logic issueWr;
  } issueStrobes_t;
endpackage

// File: rtl/ddr_spacer_dp.sv
module ddr_spacer_dp
  import ddr_spacer_pkg::*;
#(
  parameter int RANK_W = 2,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  issueStrobes_t     strb,
  input  logic [RANK_W-1:0] issueRank,
  output logic              haveLast,
  output logic              lastWasWrite,
  output logic [RANK_W-1:0] lastRank,
  output logic [CNT_W-1:0]  elapsed
);
  localparam logic [CNT_W-1:0] SAT = '1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic anyIssue;
  assign anyIssue = strb.issueRd | strb.issueWr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      haveLast     <= 1'b0;
      lastWasWrite <= 1'b0;
      lastRank     <= '0;
      elapsed      <= SAT;
    end else if (anyIssue) begin
      haveLast     <= 1'b1;
      lastWasWrite <= strb.issueWr;
      lastRank     <= issueRank;
      elapsed      <= ONE;
    end else if (elapsed != SAT) begin
      elapsed      <= elapsed + ONE;
    end
  end
endmodule

// File: rtl/ddr_spacer_ctrl.sv
module ddr_spacer_ctrl
  import ddr_spacer_pkg::*;
#(
  parameter int RANK_W    = 2,
  parameter int BURST_LEN = 4,
  parameter int CNT_W     = 4
) (
  input  logic              casLat3,
  input  logic              reqValid,
  input  logic              reqIsWrite,
  input  logic [RANK_W-1:0] reqRank,
  input  logic              haveLast,
  input  logic              lastWasWrite,
  input  logic [RANK_W-1:0] lastRank,
  input  logic [CNT_W-1:0]  elapsed,
  output logic              reqReady,
  output issueStrobes_t     strb
);
  localparam int BURST_CLKS = BURST_LEN / 2;
  localparam logic [CNT_W-1:0] GAP_RR_SAME = CNT_W'(BURST_CLKS);
  localparam logic [CNT_W-1:0] GAP_RR_DIFF = CNT_W'(BURST_CLKS + 1);
  localparam logic [CNT_W-1:0] GAP_WW      = CNT_W'(BURST_CLKS);
  localparam logic [CNT_W-1:0] GAP_WR      = CNT_W'(BURST_CLKS + 2);
  localparam logic [CNT_W-1:0] GAP_RW_CL2  = CNT_W'(2 + BURST_CLKS + 1);
  localparam logic [CNT_W-1:0] GAP_RW_CL3  = CNT_W'(3 + BURST_CLKS + 1);

  logic [CNT_W-1:0] needGap;

  always_comb begin
    unique case ({lastWasWrite, reqIsWrite})
      2'b00:   needGap = (reqRank == lastRank) ? GAP_RR_SAME : GAP_RR_DIFF;
      2'b01:   needGap = casLat3 ? GAP_RW_CL3 : GAP_RW_CL2;
      2'b10:   needGap = GAP_WR;
      default: needGap = GAP_WW;
    endcase
  end

  assign reqReady     = !haveLast || (elapsed >= needGap);
  assign strb.issueRd = reqValid && reqReady && !reqIsWrite;
  assign strb.issueWr = reqValid && reqReady && reqIsWrite;
endmodule

// File: rtl/ddr_cmd_spacer.sv
module ddr_cmd_spacer
  import ddr_spacer_pkg::*;
#(
  parameter int RANK_W    = 2,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              casLat3,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqIsWrite,
  input  logic [RANK_W-1:0] reqRank,
  output logic [1:0]        cmdIssue,
  output logic [RANK_W-1:0] cmdRank
);
  localparam int MAX_GAP = 3 + BURST_LEN / 2 + 1;
  localparam int CNT_W   = $clog2(MAX_GAP + 2);

  issueStrobes_t     strb;
  logic              haveLast;
  logic              lastWasWrite;
  logic [RANK_W-1:0] lastRank;
  logic [CNT_W-1:0]  elapsed;

  ddr_spacer_ctrl #(.RANK_W(RANK_W), .BURST_LEN(BURST_LEN), .CNT_W(CNT_W)) ctrl_i (
    .casLat3(casLat3), .reqValid(reqValid), .reqIsWrite(reqIsWrite), .reqRank(reqRank),
    .haveLast(haveLast), .lastWasWrite(lastWasWrite), .lastRank(lastRank),
    .elapsed(elapsed), .reqReady(reqReady), .strb(strb)
  );

  ddr_spacer_dp #(.RANK_W(RANK_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .issueRank(reqRank),
    .haveLast(haveLast), .lastWasWrite(lastWasWrite), .lastRank(lastRank),
    .elapsed(elapsed)
  );

  assign cmdIssue = {strb.issueWr, strb.issueRd};
  assign cmdRank  = reqRank;
endmodule

// File: rtl/ddr_cmd_spacer_chk.sv
module ddr_cmd_spacer_chk #(
  parameter int RANK_W    = 2,
  parameter int BURST_LEN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              casLat3,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqIsWrite,
  input logic [RANK_W-1:0] reqRank,
  input logic [1:0]        cmdIssue,
  input logic [RANK_W-1:0] cmdRank
);
  localparam int BC  = BURST_LEN / 2;
  localparam int SAT = 15;

  int                seenCnt;
  logic              seen;
  logic              prevWr;
  logic [RANK_W-1:0] prevRank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seenCnt <= SAT; seen <= 1'b0; prevWr <= 1'b0; prevRank <= '0;
    end else if (cmdIssue != 2'b00) begin
      seenCnt <= 1; seen <= 1'b1; prevWr <= cmdIssue[1]; prevRank <= cmdRank;
    end else if (seenCnt < SAT) begin
      seenCnt <= seenCnt + 1;
    end
  end

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cmdIssue));
  p_issue_hs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdIssue != 2'b00) |-> (reqValid && reqReady));
  p_ready_fresh_r1: assert property (@(posedge clk) disable iff (!rst_n) !seen |-> reqReady);
  p_rd_rd_same_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdIssue[0] && seen && !prevWr && cmdRank == prevRank) |-> seenCnt >= BC);
  p_rd_rd_diff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdIssue[0] && seen && !prevWr && cmdRank != prevRank) |-> seenCnt >= BC + 1);
  p_wr_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdIssue[1] && seen && prevWr) |-> seenCnt >= BC);
  p_wr_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdIssue[0] && seen && prevWr) |-> seenCnt >= BC + 2);
  p_rd_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdIssue[1] && seen && !prevWr) |-> seenCnt >= (casLat3 ? 3 : 2) + BC + 1);
  p_idle_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && seenCnt == SAT) |-> reqReady);
endmodule

bind ddr_cmd_spacer ddr_cmd_spacer_chk #(.RANK_W(RANK_W), .BURST_LEN(BURST_LEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .casLat3(casLat3), .reqValid(reqValid), .reqReady(reqReady),
  .reqIsWrite(reqIsWrite), .reqRank(reqRank), .cmdIssue(cmdIssue), .cmdRank(cmdRank)
);

// File: tb/ddr_cmd_spacer_tb.sv
module ddr_cmd_spacer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       casLat3 = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic       reqIsWrite = 1'b0;
  logic [1:0] reqRank = 2'd0;
  logic [1:0] cmdIssue;
  logic [1:0] cmdRank;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  typedef struct { logic isWr; logic [1:0] rank; int presentCyc; } item_t;
  item_t expQ[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ddr_cmd_spacer dut_i (
    .clk(clk), .rst_n(rst_n), .casLat3(casLat3), .reqValid(reqValid), .reqReady(reqReady),
    .reqIsWrite(reqIsWrite), .reqRank(reqRank), .cmdIssue(cmdIssue), .cmdRank(cmdRank)
  );

  function automatic int ruleGap(logic pw, logic [1:0] pr, logic w, logic [1:0] r, logic cl3);
    if (!pw && !w) return (pr == r) ? 2 : 3;
    if (pw && w)   return 2;
    if (pw && !w)  return 4;
    return (cl3 ? 3 : 2) + 3;
  endfunction

  function automatic string ruleTag(logic pw, logic [1:0] pr, logic w, logic [1:0] r);
    if (!pw && !w) return (pr == r) ? "R3" : "R4";
    if (pw && w)   return "R5";
    if (pw && !w)  return "R6";
    return "R7";
  endfunction

  // monitor: pop expected item on every issue, compare type, rank and cycle
  logic       haveHist = 1'b0;
  logic       histWr;
  logic [1:0] histRank;
  int         histCyc;
  always @(negedge clk) begin
    if (rst_n) begin
      if (reqValid && !reqReady) begin
        tests++;
        if (cmdIssue != 2'b00) begin
          fails++;
          $display("FAIL R8: issue while not ready, got %b expected 00", cmdIssue);
        end
      end
      if (cmdIssue != 2'b00) begin
        item_t it;
        int expCyc;
        string tag;
        tests++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R2: unexpected issue %b, expected none", cmdIssue);
        end else begin
          it = expQ.pop_front();
          if (cmdIssue != (it.isWr ? 2'b10 : 2'b01) || cmdRank != it.rank) begin
            fails++;
            $display("FAIL R2: cmd %b rank %0d, expected %b rank %0d",
                     cmdIssue, cmdRank, it.isWr ? 2'b10 : 2'b01, it.rank);
          end
          if (!haveHist) begin
            expCyc = it.presentCyc; tag = "R1";
          end else begin
            expCyc = histCyc + ruleGap(histWr, histRank, it.isWr, it.rank, casLat3);
            tag = ruleTag(histWr, histRank, it.isWr, it.rank);
            if (it.presentCyc > expCyc) begin expCyc = it.presentCyc; tag = "R9"; end
          end
          tests++;
          if (cyc != expCyc) begin
            fails++;
            $display("FAIL %s: issued at cycle %0d, expected %0d", tag, cyc, expCyc);
          end
          haveHist = 1'b1; histWr = it.isWr; histRank = it.rank; histCyc = cyc;
        end
      end
    end
  end

  task automatic sendReq(input logic wr, input logic [1:0] rk);
    item_t it;
    it.isWr = wr; it.rank = rk; it.presentCyc = cyc;
    expQ.push_back(it);
    reqValid = 1'b1; reqIsWrite = wr; reqRank = rk;
    forever begin
      @(negedge clk);
      if (reqReady) break;
    end
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    tests++;
    if (reqReady !== 1'b1 || cmdIssue !== 2'b00) begin
      fails++;
      $display("FAIL R1: ready %b issue %b, expected 1 00", reqReady, cmdIssue);
    end
    @(posedge clk); #1;

    // CAS latency 2 sequence
    sendReq(1'b0, 2'd0);   // first after reset (R1)
    sendReq(1'b0, 2'd0);   // same rank read (R3)
    sendReq(1'b0, 2'd1);   // different rank read (R4)
    sendReq(1'b1, 2'd2);   // read to write CL2 (R7)
    sendReq(1'b1, 2'd3);   // write to write (R5)
    sendReq(1'b0, 2'd1);   // write to read (R6)
    sendReq(1'b0, 2'd1);   // same rank (R3)
    idle(1);
    sendReq(1'b0, 2'd2);   // different rank after partial idle (R4)
    idle(10);
    sendReq(1'b1, 2'd0);   // long idle, immediate (R9)
    sendReq(1'b1, 2'd0);   // R5

    // CAS latency 3
    casLat3 = 1'b1;
    sendReq(1'b0, 2'd3);   // R6
    sendReq(1'b1, 2'd3);   // read to write CL3 (R7)
    sendReq(1'b0, 2'd0);   // R6
    sendReq(1'b0, 2'd3);   // R4
    sendReq(1'b0, 2'd3);   // R3
    idle(3);
    sendReq(1'b1, 2'd1);   // R7 with partial idle
    idle(6);

    tests++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d requests never issued, expected 0", expQ.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule